// File: doc/BRIEF.md
# Least-Writes Victim Selector

This block chooses which entry of a small SRAM side store should give up its slot when a heavily written cache block wants to move in. Each side-store entry holds the data of one cache block. The manager reads that block's saturating write counter and presents one count per entry, together with a valid bit per entry. On a start pulse the selector captures these inputs. A fixed number of cycles later it reports a victim: an empty entry if one exists, or otherwise the occupied entry whose block has been written least. The manager then compares the reported count with the count of the incoming block. It replaces the victim only when the victim's count is strictly lower. That comparison belongs to the manager, not to this block.

A second mode picks the victim by a not-recently-used bit per entry in place of the write counts. The selector keeps these bits itself. Each access to an entry sets its bit. When a search finds every bit set, it clears all of them except the bit of the most recently accessed entry and picks from the result. The search is a pipelined minimum tree, so it can be launched well before the manager needs the answer, and a new search can start on every cycle.

Top module: `writes_victim_sel`

## Requirements
- R1: While reset is held and in the first cycle after it, `done` and `victim_free` are 0, and `victim_idx` and `victim_cnt` are 0.
- R2: A search started by `start` high in cycle c raises `done` for exactly one cycle, in cycle c+4. `done` is never high without such a start.
- R3: With `mode_nru`=0 and every entry valid, the result is the entry with the smallest count. `victim_cnt` equals that count, and `victim_free` is 0.
- R4: In least-writes mode, when several entries share the smallest count, the lowest entry index is reported.
- R5: In either mode, if any entry is invalid, the lowest-index invalid entry is reported with `victim_free`=1 and with `victim_cnt` equal to that entry's count input. Counts and recency bits are then not considered.
- R6: With `mode_nru`=1 and every entry valid, the result is the lowest-index entry whose recency bit is clear. `victim_cnt` is that entry's count input.
- R7: All recency bits are clear after reset. A `touch_valid` pulse with index i sets bit i and makes i the most recently accessed entry.
- R8: A recency-mode search that finds every bit set first clears all bits except that of the most recently accessed entry. It reports the lowest-index other entry. Later searches see only that one bit, plus any bits set by later accesses.
- R9: `victim_idx`, `victim_cnt` and `victim_free` keep their values in every cycle in which `done` is low.
- R10: Starts in consecutive cycles each produce their own result, in consecutive cycles and in the order they were started.
- R11: The valid bits, counts and mode are taken in the start cycle. Changing them afterwards does not alter that search's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a search using this cycle's inputs |
| mode_nru | input | 1 | 0 = least-writes, 1 = not-recently-used |
| entry_valid | input | NUM_ENTRIES | Per-entry occupied flag |
| entry_count | input | NUM_ENTRIES*CNT_W | Per-entry write count, entry i at bits [i*CNT_W +: CNT_W] |
| touch_valid | input | 1 | An entry was accessed this cycle |
| touch_idx | input | IDX_W | Index of the accessed entry |
| done | output | 1 | Result valid, one cycle per search |
| victim_idx | output | IDX_W | Chosen entry |
| victim_cnt | output | CNT_W | Count input of the chosen entry |
| victim_free | output | 1 | Chosen entry is empty |

## Verification
The bench builds the selector with NUM_ENTRIES=12 and CNT_W=8. Twelve is not a power of two, so the tree is padded to sixteen leaves. That case lets the bench check that padded leaves never win, even against a real entry whose count is saturated at 255. With four tree levels, the first level is combinational and the last three are registered, so the uneven split of levels over the fixed latency is exercised. Twelve entries can all be touched within a short run, which brings the fold of all-set recency bits, and its after-effect on the next search, within reach.

// File: rtl/vsel_pkg.sv
// Package: shared types for the least-writes victim selector.
// Assumes nothing beyond IEEE 1800-2017 packages.
package vsel_pkg;

    // Search policy selected per request.
    typedef enum logic {
        SEL_LEAST_WRITES = 1'b0,
        SEL_NRU          = 1'b1
    } sel_mode_e;

endpackage

// File: rtl/vsel_nru_track.sv
// Module: vsel_nru_track
// Keeps one recency bit per side-store entry and the index of the most
// recently accessed entry. Presents the bits a search should use. When
// all bits are set, those are the folded bits (only the MRU entry set).
// The stored bits are folded when a recency-mode search is launched.
// Assumes touch_idx values at or above N are ignored.
module vsel_nru_track #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fold_req,
    input  logic          touch_valid,
    input  logic [IW-1:0] touch_idx,
    output logic [N-1:0]  eff_bits
);

    logic [N-1:0]  used_q;
    logic [N-1:0]  used_d;
    logic [IW-1:0] mru_q;
    logic          all_set;
    logic          touch_ok;
    logic [N-1:0]  mru_onehot;

    // Decode the MRU index and detect a full bit vector.
    always_comb begin
        mru_onehot = '0;
        for (int i = 0; i < N; i++) begin
            mru_onehot[i] = (mru_q == IW'(i));
        end
        all_set  = &used_q;
        touch_ok = touch_valid && ({1'b0, touch_idx} < (IW+1)'(N));
        eff_bits = all_set ? mru_onehot : used_q;
    end

    // Next bit state: fold on a saturated search, then apply an access.
    always_comb begin
        used_d = used_q;
        if (fold_req && all_set) begin
            used_d = mru_onehot;
        end
        if (touch_ok) begin
            used_d[touch_idx] = 1'b1;
        end
    end

    // Bit and MRU registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= '0;
            mru_q  <= '0;
        end else begin
            used_q <= used_d;
            if (touch_ok) begin
                mru_q <= touch_idx;
            end
        end
    end

    AST_TOUCH_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        touch_ok |=> used_q[$past(touch_idx)]); // R7

    AST_FOLD_LEAVES_FEW: assert property (@(posedge clk) disable iff (!rst_n)
        (fold_req && all_set) |=> ($countones(used_q) <= 2)); // R8

endmodule

// File: rtl/vsel_key_load.sv
// Module: vsel_key_load
// First pipeline stage. On start it captures one sort key and one count
// per entry. The key's top bit is the valid flag, so empty entries (key 0)
// sort first. The lower bits hold the write count in least-writes mode, or
// the recency bit followed by zeros in recency mode.
// Assumes CW >= 1.
module vsel_key_load
    import vsel_pkg::*;
#(
    parameter int N  = 16,
    parameter int CW = 8,
    parameter int KW = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  sel_mode_e     mode,
    input  logic [N-1:0]  entry_valid,
    input  logic [N*CW-1:0] entry_count,
    input  logic [N-1:0]  eff_bits,
    output logic          snap_vld,
    output logic [N*KW-1:0] snap_key,
    output logic [N*CW-1:0] snap_cnt
);

    logic [CW-1:0] low_part [N];

    // Lower key bits depending on the selected policy.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (mode == SEL_NRU) begin
                low_part[i] = {eff_bits[i], {(CW-1){1'b0}}};
            end else begin
                low_part[i] = entry_count[i*CW +: CW];
            end
        end
    end

    // Snapshot registers, loaded only on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_vld <= 1'b0;
            snap_key <= '0;
            snap_cnt <= '0;
        end else begin
            snap_vld <= start;
            if (start) begin
                for (int i = 0; i < N; i++) begin
                    snap_key[i*KW +: KW] <= entry_valid[i] ? {1'b1, low_part[i]} : '0;
                    snap_cnt[i*CW +: CW] <= entry_count[i*CW +: CW];
                end
            end
        end
    end

endmodule

// File: rtl/vsel_min_tree.sv
// Module: vsel_min_tree
// Pipelined minimum-key tree over N leaves, padded to a power of two with
// leaves that carry the largest key. At each node the left child wins ties,
// so the lowest index wins among equal keys. Three of the levels are
// registered, spread evenly down the tree, and the rest are combinational.
// The registers load only when data is flowing, so the last level holds
// its result until the next search arrives.
// Assumes N >= 8, so the tree has at least three levels.
module vsel_min_tree #(
    parameter int N  = 16,
    parameter int CW = 8,
    parameter int IW = 4,
    parameter int KW = CW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [N*KW-1:0] in_key,
    input  logic [N*CW-1:0] in_cnt,
    output logic            out_vld,
    output logic [KW-1:0]   out_key,
    output logic [IW-1:0]   out_idx,
    output logic [CW-1:0]   out_cnt
);

    localparam int L  = $clog2(N);
    localparam int P  = 1 << L;
    localparam int RA = (L + 2) / 3;
    localparam int RB = (2 * L + 2) / 3;

    for (genvar lv = 0; lv <= L; lv++) begin : g_lvl
        localparam int W = P >> lv;
        logic [KW-1:0] key [W];
        logic [IW-1:0] idx [W];
        logic [CW-1:0] cnt [W];
        logic          vld;

        if (lv == 0) begin : g_leaf
            assign vld = in_vld;
            for (genvar j = 0; j < W; j++) begin : g_in
                if (j < N) begin : g_real
                    assign key[j] = in_key[j*KW +: KW];
                    assign cnt[j] = in_cnt[j*CW +: CW];
                end else begin : g_pad
                    assign key[j] = '1;
                    assign cnt[j] = '0;
                end
                assign idx[j] = IW'(j);
            end
        end else begin : g_node
            logic [KW-1:0] nk [W];
            logic [IW-1:0] ni [W];
            logic [CW-1:0] nc [W];

            // Pairwise pick: the lower key wins, the left child wins ties.
            for (genvar j = 0; j < W; j++) begin : g_pick
                logic left_wins;
                assign left_wins = (g_lvl[lv-1].key[2*j] <= g_lvl[lv-1].key[2*j+1]);
                assign nk[j] = left_wins ? g_lvl[lv-1].key[2*j] : g_lvl[lv-1].key[2*j+1];
                assign ni[j] = left_wins ? g_lvl[lv-1].idx[2*j] : g_lvl[lv-1].idx[2*j+1];
                assign nc[j] = left_wins ? g_lvl[lv-1].cnt[2*j] : g_lvl[lv-1].cnt[2*j+1];
            end

            if (lv == RA || lv == RB || lv == L) begin : g_reg
                // Registered level, loaded only when the level above is valid.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        vld <= 1'b0;
                        for (int j = 0; j < W; j++) begin
                            key[j] <= '1;
                            idx[j] <= '0;
                            cnt[j] <= '0;
                        end
                    end else begin
                        vld <= g_lvl[lv-1].vld;
                        if (g_lvl[lv-1].vld) begin
                            for (int j = 0; j < W; j++) begin
                                key[j] <= nk[j];
                                idx[j] <= ni[j];
                                cnt[j] <= nc[j];
                            end
                        end
                    end
                end
            end else begin : g_comb
                // Combinational level passing its picks straight through.
                always_comb begin
                    vld = g_lvl[lv-1].vld;
                    for (int j = 0; j < W; j++) begin
                        key[j] = nk[j];
                        idx[j] = ni[j];
                        cnt[j] = nc[j];
                    end
                end
            end
        end
    end

    assign out_vld = g_lvl[L].vld;
    assign out_key = g_lvl[L].key[0];
    assign out_idx = g_lvl[L].idx[0];
    assign out_cnt = g_lvl[L].cnt[0];

endmodule

// File: rtl/writes_victim_sel.sv
// Module: writes_victim_sel (top)
// Picks a replacement candidate among side-store entries: the lowest empty
// entry, else the lowest-count entry (least-writes mode) or the lowest entry
// with a clear recency bit (recency mode). The result appears four cycles
// after start and holds until the next result. One search can start per cycle.
// Assumes NUM_ENTRIES >= 8 and that the manager supplies the counts.
module writes_victim_sel
    import vsel_pkg::*;
#(
    parameter  int NUM_ENTRIES = 16,
    parameter  int CNT_W       = 8,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      mode_nru,
    input  logic [NUM_ENTRIES-1:0]    entry_valid,
    input  logic [NUM_ENTRIES*CNT_W-1:0] entry_count,
    input  logic                      touch_valid,
    input  logic [IDX_W-1:0]          touch_idx,
    output logic                      done,
    output logic [IDX_W-1:0]          victim_idx,
    output logic [CNT_W-1:0]          victim_cnt,
    output logic                      victim_free
);

    localparam int KEY_W = CNT_W + 1;

    sel_mode_e                      mode;
    logic [NUM_ENTRIES-1:0]         eff_bits;
    logic                           snap_vld;
    logic [NUM_ENTRIES*KEY_W-1:0]   snap_key;
    logic [NUM_ENTRIES*CNT_W-1:0]   snap_cnt;
    logic [KEY_W-1:0]               res_key;

    assign mode = sel_mode_e'(mode_nru);

    vsel_nru_track #(
        .N  (NUM_ENTRIES),
        .IW (IDX_W)
    ) u_nru (
        .clk         (clk),
        .rst_n       (rst_n),
        .fold_req    (start && (mode == SEL_NRU)),
        .touch_valid (touch_valid),
        .touch_idx   (touch_idx),
        .eff_bits    (eff_bits)
    );

    vsel_key_load #(
        .N  (NUM_ENTRIES),
        .CW (CNT_W),
        .KW (KEY_W)
    ) u_load (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mode        (mode),
        .entry_valid (entry_valid),
        .entry_count (entry_count),
        .eff_bits    (eff_bits),
        .snap_vld    (snap_vld),
        .snap_key    (snap_key),
        .snap_cnt    (snap_cnt)
    );

    vsel_min_tree #(
        .N  (NUM_ENTRIES),
        .CW (CNT_W),
        .IW (IDX_W),
        .KW (KEY_W)
    ) u_tree (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (snap_vld),
        .in_key  (snap_key),
        .in_cnt  (snap_cnt),
        .out_vld (done),
        .out_key (res_key),
        .out_idx (victim_idx),
        .out_cnt (victim_cnt)
    );

    // An all-zero key can only come from an empty entry.
    assign victim_free = ~res_key[KEY_W-1];

    AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start, 4) && $past(rst_n, 4) && $past(rst_n, 3)
         && $past(rst_n, 2) && $past(rst_n, 1)) |-> done); // R2

    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, 4)); // R2

    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(victim_idx) && $stable(victim_cnt) && $stable(victim_free))); // R9

endmodule

// File: tb/writes_victim_sel_tb.sv
// Scoreboard bench: the launch task predicts each result from a model of
// the requirements and queues it, and a monitor compares it when done rises.
module writes_victim_sel_tb;

    localparam int N  = 12;
    localparam int CW = 8;
    localparam int IW = $clog2(N);

    typedef struct {
        int    due;
        int    idx;
        int    cnt;
        int    free;
        string tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            mode_nru = 1'b0;
    logic [N-1:0]    entry_valid = '0;
    logic [N*CW-1:0] entry_count = '0;
    logic            touch_valid = 1'b0;
    logic [IW-1:0]   touch_idx = '0;
    logic            done;
    logic [IW-1:0]   victim_idx;
    logic [CW-1:0]   victim_cnt;
    logic            victim_free;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    exp_t q[$];
    exp_t last_e;
    int   cnt_m [N];
    bit   val_m [N];
    bit   nru_m [N];
    int   mru_m = 0;
    bit   finished = 1'b0;

    writes_victim_sel #(.NUM_ENTRIES(N), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_nru(mode_nru),
        .entry_valid(entry_valid), .entry_count(entry_count),
        .touch_valid(touch_valid), .touch_idx(touch_idx),
        .done(done), .victim_idx(victim_idx), .victim_cnt(victim_cnt),
        .victim_free(victim_free)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic apply();
        for (int i = 0; i < N; i++) begin
            entry_valid[i]         = val_m[i];
            entry_count[i*CW +: CW] = CW'(cnt_m[i]);
        end
    endtask

    // Driver: predict, queue, and pulse start for one cycle.
    task automatic launch(bit nru, string tag);
        exp_t e;
        int   v = -1;
        bit   all = 1'b1;
        if (nru) begin
            for (int i = 0; i < N; i++) if (!nru_m[i]) all = 1'b0;
            if (all) for (int i = 0; i < N; i++) nru_m[i] = (i == mru_m);
        end
        for (int i = 0; i < N; i++) if (!val_m[i] && v < 0) v = i;
        e.free = (v >= 0);
        if (v < 0) begin
            if (!nru) begin
                v = 0;
                for (int i = 1; i < N; i++) if (cnt_m[i] < cnt_m[v]) v = i;
            end else begin
                for (int i = N - 1; i >= 0; i--) if (!nru_m[i]) v = i;
            end
        end
        e.idx = v;
        e.cnt = cnt_m[v];
        e.tag = tag;
        e.due = cyc + 4;
        apply();
        mode_nru = nru;
        start = 1'b1;
        q.push_back(e);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic touch(int i);
        touch_valid = 1'b1;
        touch_idx   = IW'(i);
        nru_m[i]    = 1'b1;
        mru_m       = i;
        @(negedge clk);
        touch_valid = 1'b0;
    endtask

    task automatic drain();
        while (q.size() > 0 && !finished) @(negedge clk);
    endtask

    // Monitor: compare each result against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                check("R2", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                last_e = e;
                check(e.tag, "done cycle (R2)", cyc, e.due);
                check(e.tag, "victim_idx", int'(victim_idx), e.idx);
                check(e.tag, "victim_cnt", int'(victim_cnt), e.cnt);
                check(e.tag, "victim_free", int'(victim_free), e.free);
            end
        end else if (rst_n && q.size() > 0 && cyc > q[0].due) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, "missing done (R2)", 0, 1);
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check("R2", "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            cnt_m[i] = 0;
            val_m[i] = 1'b1;
            nru_m[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check("R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "done after reset", int'(done), 0);
        check("R1", "victim_idx after reset", int'(victim_idx), 0);
        check("R1", "victim_cnt after reset", int'(victim_cnt), 0);
        check("R1", "victim_free after reset", int'(victim_free), 0);

        // R7: recency bits start clear, so entry 0 is picked.
        launch(1'b1, "R7");
        drain();

        // R3: minimum of distinct counts.
        cnt_m = '{50, 40, 90, 30, 70, 60, 80, 45, 95, 85, 35, 65};
        launch(1'b0, "R3");
        drain();

        // R4: ties go to the lower index.
        cnt_m[7] = 20; cnt_m[9] = 20; cnt_m[11] = 20;
        launch(1'b0, "R4");
        drain();

        // R3: saturated counts everywhere, padding must not win.
        for (int i = 0; i < N; i++) cnt_m[i] = 255;
        launch(1'b0, "R3");
        drain();
        cnt_m[11] = 0;
        launch(1'b0, "R3");
        drain();

        // R9: outputs hold while done is low.
        repeat (6) @(negedge clk);
        check("R9", "held victim_idx", int'(victim_idx), last_e.idx);
        check("R9", "held victim_cnt", int'(victim_cnt), last_e.cnt);

        // R5: empty entries win in least-writes mode.
        val_m[9] = 1'b0; val_m[5] = 1'b0; cnt_m[5] = 77;
        launch(1'b0, "R5");
        drain();
        val_m[5] = 1'b1; val_m[9] = 1'b1;

        // R11: inputs changed right after start do not matter.
        cnt_m = '{9, 8, 7, 6, 5, 4, 3, 2, 10, 11, 12, 13};
        launch(1'b0, "R11");
        cnt_m[0] = 1;
        apply();
        drain();

        // R10: back-to-back starts.
        cnt_m[0] = 1;
        launch(1'b0, "R10");
        cnt_m[0] = 100; cnt_m[4] = 0;
        launch(1'b0, "R10");
        drain();

        // R6: lowest clear recency bit.
        touch(0); touch(1); touch(2);
        launch(1'b1, "R6");
        drain();

        // R8: all bits set with MRU 0 folds, picks entry 1.
        for (int i = 3; i < N; i++) touch(i);
        touch(1); touch(0);
        launch(1'b1, "R8");
        drain();
        // R8: after the fold only bits 0 and 1 are set.
        touch(1);
        launch(1'b1, "R8");
        drain();

        // R5: empty entry wins in recency mode too.
        val_m[7] = 1'b0; cnt_m[7] = 33;
        launch(1'b1, "R5");
        drain();

        repeat (3) @(negedge clk);
        check("R2", "results outstanding", q.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule